// File: doc/BRIEF.md
# External Memory Wait-State Controller

This block sits between a fast soft CPU and a memory map that is split between fast on-chip block RAM and a slow external device. It decodes the CPU address. The top address bit selects the memory. Internal accesses complete with no wait. External accesses hold the CPU ready line low until a programmable wait has run out.

The wait is counted on a separate counter clock that is faster than the CPU clock, so the delay can be set in steps finer than one CPU cycle. The terminal-count flag is synchronised back into the CPU clock domain. The CPU can therefore only resume on one of its own clock edges, and any fraction of a CPU cycle is rounded up to a whole cycle.

The request and the completion flag form a return-to-zero handshake between the two clock domains. This handshake keeps a stale completion from releasing a later access.

Top module: `ewc_wait_ctrl`

## Requirements
- R1: `ext_addr` always equals bits 18..0 of `cpu_addr`.
- R2: When `cpu_addr[19]` is 0, `ext_ce_n` stays 1, and `int_sel` is 1 while a strobe (`cpu_rd` or `cpu_wr`) is high. When `cpu_addr[19]` is 1 and a strobe is high, `ext_ce_n` is 0 and `int_sel` is 0.
- R3: `cpu_ready` is 1 in every cycle that has no external access pending, including internal accesses and idle cycles.
- R4: `cpu_ready` drops combinationally in the same CPU cycle in which an external strobe first appears.
- R5: The rules for a fresh external access are as follows. The CPU edge that sees the strobe registers a request. The request takes two counter-clock flops to reach the counter. The done flag then rises on the (cfg_wait+1)-th counter edge after that. The done flag passes two CPU-clock flops, and `cpu_ready` rises in the cycle after the second one.
- R6: A `cfg_wait` of 0 completes with only the synchroniser latency. Two counts that finish inside the same CPU cycle give the same number of CPU wait cycles.
- R7: `cpu_ready` is high for exactly one CPU cycle per external access. If the strobe stays high after that cycle, a new wait starts. That wait only begins once the previous completion has returned to zero, so it takes two CPU cycles more than a fresh access.
- R8: The counter clears whenever the request is released. An access abandoned before ready does not shorten a later access.
- R9: After reset, with no strobe, `cpu_ready` is 1, `ext_ce_n` is 1 and `int_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU clock |
| cpu_rst_n | input | 1 | Synchronous active-low reset, CPU domain |
| cnt_clk | input | 1 | Fast wait-counter clock |
| cnt_rst_n | input | 1 | Synchronous active-low reset, counter domain |
| cpu_addr | input | 20 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cfg_wait | input | WAIT_W | Static wait count in counter-clock cycles |
| ext_addr | output | 19 | External address bus |
| ext_ce_n | output | 1 | External chip enable, active low |
| int_sel | output | 1 | Internal block RAM select |
| cpu_ready | output | 1 | CPU may complete the access on its next edge |

## Verification
The hardest situation to reach is a new external access that starts while the previous completion is still high on the CPU side. This happens when the strobe is held straight through the ready cycle, and also when an access is abandoned and the counter still fires. The bench holds the strobe across a completed access and checks that ready drops at once and that the second wait is two cycles longer. It also withdraws a strobe after one cycle and then checks that the next access still pays the full count. The counter clock runs at four times the CPU clock with a fixed phase offset, so each sub-cycle count maps to an exact number of CPU wait cycles.

// File: rtl/ewc_pkg.sv
// Package: shared widths and the decode result type for the wait-state controller.
// Assumes a 20-bit CPU address whose top bit selects external memory.
package ewc_pkg;
    localparam int CPU_ADDR_W = 20;
    localparam int EXT_ADDR_W = CPU_ADDR_W - 1;
    localparam int SEL_BIT    = CPU_ADDR_W - 1;

    typedef struct packed {
        logic                  ext_req;
        logic                  int_sel;
        logic [EXT_ADDR_W-1:0] ext_addr;
    } decode_t;
endpackage

// File: rtl/ewc_sync.sv
// Module: multi-flop level synchroniser.
// Assumes the input is a level that stays stable longer than one destination
// clock period; depth below two is raised to two.
module ewc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[N-2:0], d};
    end

    assign q = chain[N-1];
endmodule

// File: rtl/ewc_addr_decode.sv
// Module: address decode for the split memory map.
// Assumes the top address bit selects external memory and that a strobe marks
// a live access. It has no state.
module ewc_addr_decode
    import ewc_pkg::*;
(
    input  logic [CPU_ADDR_W-1:0] addr,
    input  logic                  rd,
    input  logic                  wr,
    output decode_t               dec
);
    logic strobe;

    // Form the decode result from the select bit and the strobes.
    always_comb begin
        strobe       = rd | wr;
        dec.ext_req  = addr[SEL_BIT] & strobe;
        dec.int_sel  = ~addr[SEL_BIT] & strobe;
        dec.ext_addr = addr[EXT_ADDR_W-1:0];
    end
endmodule

// File: rtl/ewc_wait_counter.sv
// Module: wait counter in the fast counter-clock domain.
// Assumes the go level comes from a CPU-domain flop and that cfg_wait is static
// while a request is live. Done rises on the (cfg_wait+1)-th edge after the
// synchronised request, stays high while the request holds, and clears with it.
module ewc_wait_counter #(
    parameter int WAIT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_async,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              done
);
    logic              req_s;
    logic [WAIT_W-1:0] cnt_q;
    logic              done_q;

    ewc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (go_async),
        .q    (req_s)
    );

    // Count up to the configured value while the request is held.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_s) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (cnt_q == cfg_wait) begin
            done_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = done_q;

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cfg_wait);
    p_clear_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_s |=> (cnt_q == '0 && !done_q));
    p_done_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && req_s) |=> done_q);
endmodule

// File: rtl/ewc_ready_ctrl.sv
// Module: CPU-domain ready control.
// Assumes done_async comes from the counter domain. The request goes out only
// once the previous completion has returned to zero, and ready is released on
// the rising edge of the synchronised completion only.
module ewc_ready_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req,
    input  logic done_async,
    output logic go,
    output logic ready
);
    logic done_s;
    logic done_s_q;
    logic go_q;

    ewc_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (done_async),
        .q    (done_s)
    );

    // Keep the previous completion level and the registered request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_s_q <= 1'b0;
            go_q     <= 1'b0;
        end else begin
            done_s_q <= done_s;
            go_q     <= ext_req & ~done_s;
        end
    end

    assign go    = go_q;
    assign ready = ~ext_req | (done_s & ~done_s_q);

    p_ready_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ready) |=> !(ext_req && ready));
    p_no_go_while_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_s |=> !go_q);
endmodule

// File: rtl/ewc_wait_ctrl.sv
// Module: top of the external memory wait-state controller.
// Assumes cfg_wait is static and that the CPU holds its strobe and address
// until it samples ready high. The two clocks are unrelated.
module ewc_wait_ctrl
    import ewc_pkg::*;
#(
    parameter int WAIT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  cpu_clk,
    input  logic                  cpu_rst_n,
    input  logic                  cnt_clk,
    input  logic                  cnt_rst_n,
    input  logic [CPU_ADDR_W-1:0] cpu_addr,
    input  logic                  cpu_rd,
    input  logic                  cpu_wr,
    input  logic [WAIT_W-1:0]     cfg_wait,
    output logic [EXT_ADDR_W-1:0] ext_addr,
    output logic                  ext_ce_n,
    output logic                  int_sel,
    output logic                  cpu_ready
);
    decode_t dec;
    logic    go;
    logic    done;

    ewc_addr_decode u_dec (
        .addr(cpu_addr),
        .rd  (cpu_rd),
        .wr  (cpu_wr),
        .dec (dec)
    );

    ewc_ready_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
        .clk       (cpu_clk),
        .rst_n     (cpu_rst_n),
        .ext_req   (dec.ext_req),
        .done_async(done),
        .go        (go),
        .ready     (cpu_ready)
    );

    ewc_wait_counter #(.WAIT_W(WAIT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
        .clk     (cnt_clk),
        .rst_n   (cnt_rst_n),
        .go_async(go),
        .cfg_wait(cfg_wait),
        .done    (done)
    );

    // Drive the memory-side outputs from the decode.
    always_comb begin
        ext_addr = dec.ext_addr;
        ext_ce_n = ~dec.ext_req;
        int_sel  = dec.int_sel;
    end

    p_internal_muted_r2: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        !cpu_addr[SEL_BIT] |-> (ext_ce_n && cpu_ready));
endmodule

// File: tb/test_ewc_wait_ctrl.sv
// Bench: vector table of accesses with expected CPU wait cycles, then directed
// tests. CPU clock is 50 MHz (20 units); the counter clock runs at four times
// that rate, with its rising edges 1 unit after each CPU rising edge.
// With that phase, a fresh external access gives ceil((11+5*cfg)/20)+2
// sampled CPU cycles of ready low.
module test_ewc_wait_ctrl;
    logic        cpu_clk = 1'b0;
    logic        cnt_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [3:0]  cfg_wait = '0;
    logic [18:0] ext_addr;
    logic        ext_ce_n;
    logic        int_sel;
    logic        cpu_ready;

    int checks = 0;
    int failures = 0;

    localparam int NV = 10;
    localparam logic [19:0] T_ADDR [0:NV-1] = '{20'h01234, 20'h80010, 20'h80011,
        20'hFFFFF, 20'h7FFFF, 20'h9ABCD, 20'hC0000, 20'hA5A5A, 20'hE1111, 20'h00000};
    localparam logic        T_WR   [0:NV-1] = '{0, 0, 1, 0, 1, 1, 0, 0, 1, 1};
    localparam logic [3:0]  T_CFG  [0:NV-1] = '{0, 0, 1, 2, 5, 5, 6, 10, 15, 15};
    localparam int          T_EXP  [0:NV-1] = '{0, 3, 3, 4, 0, 4, 5, 6, 7, 0};

    ewc_wait_ctrl i_ewc_wait_ctrl (
        .cpu_clk  (cpu_clk),
        .cpu_rst_n(rst_n),
        .cnt_clk  (cnt_clk),
        .cnt_rst_n(rst_n),
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .cfg_wait (cfg_wait),
        .ext_addr (ext_addr),
        .ext_ce_n (ext_ce_n),
        .int_sel  (int_sel),
        .cpu_ready(cpu_ready)
    );

    always #10 cpu_clk = ~cpu_clk;

    initial begin
        #1 cnt_clk = 1'b1;
        forever begin
            #2 cnt_clk = 1'b0;
            #3 cnt_clk = 1'b1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge cpu_clk);
            cpu_rd = 1'b0;
            cpu_wr = 1'b0;
            #2;
            chk(cpu_ready == 1'b1, "R3 idle ready", cpu_ready, 1);
        end
    endtask

    // Count sampled cycles with ready low, starting at the current sample.
    task automatic count_waits(output int waits);
        waits = 0;
        while (!cpu_ready && waits < 40) begin
            waits++;
            @(negedge cpu_clk);
            #2;
        end
    endtask

    task automatic run_access(input logic [19:0] a, input logic wr, input logic [3:0] c,
                              input int exp, input string req);
        int waits;
        @(negedge cpu_clk);
        cfg_wait = c;
        cpu_addr = a;
        cpu_rd   = ~wr;
        cpu_wr   = wr;
        #2;
        chk(ext_addr == a[18:0], "R1 ext_addr", ext_addr, a[18:0]);
        chk(ext_ce_n == ~a[19], "R2 ext_ce_n", ext_ce_n, ~a[19]);
        chk(int_sel == ~a[19], "R2 int_sel", int_sel, ~a[19]);
        if (a[19]) chk(cpu_ready == 1'b0, "R4 ready drops at start", cpu_ready, 0);
        count_waits(waits);
        chk(waits == exp, req, waits, exp);
        idle(8);
    endtask

    initial begin
        int waits;
        int waits2;
        repeat (3) @(negedge cpu_clk);
        #2;
        // R9: reset state
        chk(cpu_ready == 1'b1, "R9 ready in reset", cpu_ready, 1);
        chk(ext_ce_n == 1'b1, "R9 ce_n in reset", ext_ce_n, 1);
        @(negedge cpu_clk);
        rst_n = 1'b1;
        #2;
        chk(cpu_ready == 1'b1, "R9 ready after reset", cpu_ready, 1);
        chk(ext_ce_n == 1'b1, "R9 ce_n after reset", ext_ce_n, 1);
        chk(int_sel == 1'b0, "R9 int_sel after reset", int_sel, 0);
        idle(4);

        // Table walk: R3 internal no-wait, R5 and R6 wait lengths
        for (int v = 0; v < NV; v++) begin
            run_access(T_ADDR[v], T_WR[v], T_CFG[v], T_EXP[v],
                       T_ADDR[v][19] ? "R5 R6 wait cycles" : "R3 internal wait cycles");
        end

        // R7: strobe held through the ready cycle starts a longer second wait
        @(negedge cpu_clk);
        cfg_wait = 4'd3;
        cpu_addr = 20'hB0F0F;
        cpu_rd   = 1'b1;
        #2;
        count_waits(waits);
        chk(waits == 4, "R7 first wait", waits, 4);
        @(negedge cpu_clk);
        #2;
        chk(cpu_ready == 1'b0, "R7 ready one cycle only", cpu_ready, 0);
        count_waits(waits2);
        chk(waits2 == 6, "R7 held strobe second wait", waits2, 6);
        idle(8);

        // R8: abandoned access does not shorten the next one
        @(negedge cpu_clk);
        cfg_wait = 4'd3;
        cpu_addr = 20'hD0001;
        cpu_wr   = 1'b1;
        #2;
        chk(cpu_ready == 1'b0, "R4 ready low on abandoned start", cpu_ready, 0);
        idle(10);
        run_access(20'hD0002, 1'b0, 4'd3, 4, "R8 wait after abandon");

        // R8: abandon late, right before completion, then go again at once
        @(negedge cpu_clk);
        cpu_addr = 20'hD0003;
        cpu_rd   = 1'b1;
        #2;
        @(negedge cpu_clk);
        #2;
        @(negedge cpu_clk);
        cpu_rd = 1'b0;
        idle(12);
        run_access(20'hD0004, 1'b1, 4'd3, 4, "R8 wait after late abandon");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule